// File: doc/BRIEF.md
# Low-Power ADC Scan Sequencer

This block is the sequencing core of a controller for a two-channel, 10-bit ADC. It runs on a slow always-on clock, powers the converter up and down, selects each channel in turn with a one-hot select, and stores the latest result from each channel. After every complete round, a filter bank outside the block reports a match vector. The sequencer debounces that vector by counting consecutive rounds that report the same non-zero vector.

Three operating styles are supported. In oneshot mode the block converts both channels once, ignores the filter vector and signals completion. In continuous mode the converter stays powered and rounds follow each other back to back. In low-power mode the converter is powered off between rounds and woken on a programmable interval. Once a first, low-power match count has been reached, the converter stays powered until a second, normal-power count confirms the match. Each power-up is followed by a programmable delay and one extra settling cycle before any channel is selected.

Top module: `adc_scan_seq`

## Requirements
- R1: While `cfg_enable_i` is 0 the block sits in its idle state. From the cycle after enable is seen low, `adc_pd_o` is 1, `adc_sel_o` is 0 and no event pulses are produced.
- R2: After every power-up, `adc_pd_o` is low and `adc_sel_o` is 0 for P+1 cycles before the first channel is selected. P is `cfg_pwrup_i`, with 0 treated as 1. The extra cycle is a settling cycle.
- R3: In low-power mode, while the debounce is still in its low-power phase, the converter is powered down between rounds. `adc_pd_o` stays high for W cycles, where W is `cfg_wake_i` with 0 treated as 1. A new power-up follows.
- R4: In low-power mode, once `cfg_lp_cnt_i` matching rounds have been counted, the count restarts at zero and the converter stays powered for the following rounds (normal-power phase).
- R5: `adc_sel_o` is one-hot or zero. Bit 0 (channel 0) is selected first and bit 1 (channel 1) second. A select is held until `adc_valid_i` is seen.
- R6: The value on `adc_data_i` is stored for the selected channel on the clock edge where `adc_valid_i` is high, and is visible the next cycle. Channel 0 occupies `chan_val_o[9:0]` and channel 1 occupies `chan_val_o[19:10]`.
- R7: While `cfg_swrst_i` is 1 the block is held idle (`adc_pd_o`=1, `adc_sel_o`=0) and the debounce state is cleared. After release it restarts with a fresh power-up.
- R8: In oneshot mode one round is taken and the filter vector is ignored. `oneshot_done_o` pulses for one cycle, on the cycle after the channel-1 valid. The block then holds `adc_pd_o`=1 and `adc_sel_o`=0 until enable drops.
- R9: A round counts as matching only if its filter vector, sampled with the channel-1 valid, is non-zero and equal to the previous round's vector. Any other round sets the count to zero.
- R10: When the count reaches `cfg_np_cnt_i` (0 treated as 1) in continuous mode or in the normal-power phase, `match_o` pulses for one cycle on the cycle after the round ends, and `match_vec_o` carries the vector. The count then restarts at zero.
- R11: In low-power mode, a mismatching round in the normal-power phase, or a confirmed match, returns the debounce to the low-power phase, and the converter powers down before the next round.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_enable_i | input | 1 | Run enable |
| cfg_oneshot_i | input | 1 | Oneshot mode select |
| cfg_lowpwr_i | input | 1 | Low-power periodic mode select |
| cfg_pwrup_i | input | 4 | Power-up delay in cycles |
| cfg_wake_i | input | 24 | Power-down interval in cycles |
| cfg_lp_cnt_i | input | 8 | Matching rounds needed in the low-power phase |
| cfg_np_cnt_i | input | 16 | Matching rounds needed to confirm a match |
| cfg_swrst_i | input | 1 | Soft reset of machine, timer and debounce |
| adc_valid_i | input | 1 | Converter result strobe |
| adc_data_i | input | 10 | Converter result |
| filt_match_i | input | 8 | Filter match vector for the current round |
| adc_pd_o | output | 1 | Converter power-down |
| adc_sel_o | output | 2 | One-hot channel select |
| chan_val_o | output | 20 | Latest result per channel |
| oneshot_done_o | output | 1 | Oneshot round complete pulse |
| match_o | output | 1 | Debounced match pulse |
| match_vec_o | output | 8 | Vector of the last confirmed match |

## Verification
A stored channel value is due one cycle after its valid strobe. `match_o` and `oneshot_done_o` are due one cycle after the channel-1 valid. Power-down and select react one cycle after enable or soft reset changes. The bench drives inputs 1 ns after a falling edge and samples every output at falling edges. Its converter model records which round each event belongs to, so a pulse is credited to the round whose valid produced it. Power-up and sleep lengths are measured by counting falling edges with `adc_pd_o` and `adc_sel_o` in the states R2 and R3 name.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PWRUP,
    ST_SETTLE,
    ST_SAMPLE,
    ST_SLEEP,
    ST_DONE
  } scan_state_e;

endpackage

// File: rtl/adc_scan_timer.sv
// Cycle timer shared by the power-up delay and the sleep interval.
module adc_scan_timer #(
  parameter int W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic [W-1:0] lim_i,
  output logic         exp_o
);

  logic [W-1:0] cnt_q, cnt_d;
  logic [W:0]   cnt_nxt;

  assign cnt_nxt = {1'b0, cnt_q} + 1'b1;
  // Expires on the cycle that completes lim_i cycles; a zero limit acts as one.
  assign exp_o   = cnt_nxt >= {1'b0, lim_i};

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)     cnt_d = '0;
    else if (en_i) cnt_d = cnt_nxt[W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

endmodule

// File: rtl/adc_scan_capture.sv
// Per-channel result registers.
module adc_scan_capture #(
  parameter int NCH = 2,
  parameter int DW  = 10,
  parameter int CW  = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [CW-1:0]     ch_i,
  input  logic [DW-1:0]     data_i,
  output logic [NCH*DW-1:0] val_o
);

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    logic [DW-1:0] val_q;
    logic          hit;
    assign hit = load_i && (ch_i == CW'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  val_q <= '0;
      else if (hit) val_q <= data_i;
    end
    assign val_o[g*DW +: DW] = val_q;
  end

endmodule

// File: rtl/adc_scan_debounce.sv
// Two-tier round debounce: low-power phase, then normal-power phase.
module adc_scan_debounce #(
  parameter int NF   = 8,
  parameter int LP_W = 8,
  parameter int NP_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            round_i,
  input  logic            lowpwr_i,
  input  logic [LP_W-1:0] lp_need_i,
  input  logic [NP_W-1:0] np_need_i,
  input  logic [NF-1:0]   vec_i,
  output logic            fire_o,
  output logic            sleep_o
);

  localparam int CNT_W = ((NP_W > LP_W) ? NP_W : LP_W) + 1;

  logic [NF-1:0]    prev_q, prev_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc, need;
  logic             np_q, np_d;
  logic             hit, reached, final_tier;

  assign hit        = (vec_i != '0) && (vec_i == prev_q);
  assign cnt_inc    = hit ? cnt_q + 1'b1 : '0;
  assign final_tier = np_q || !lowpwr_i;
  assign need       = final_tier ? CNT_W'(np_need_i) : CNT_W'(lp_need_i);
  // A zero threshold behaves as one: a hit always makes cnt_inc at least one.
  assign reached    = hit && (cnt_inc >= need);

  assign fire_o  = round_i && reached && final_tier;
  assign sleep_o = lowpwr_i && (np_q ? (!hit || reached) : !reached);

  always_comb begin
    prev_d = prev_q;
    cnt_d  = cnt_q;
    np_d   = np_q;
    if (clr_i) begin
      prev_d = '0;
      cnt_d  = '0;
      np_d   = 1'b0;
    end else if (round_i) begin
      prev_d = vec_i;
      cnt_d  = reached ? '0 : cnt_inc;
      np_d   = lowpwr_i && (np_q ? (hit && !reached) : reached);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      cnt_q  <= '0;
      np_q   <= 1'b0;
    end else begin
      prev_q <= prev_d;
      cnt_q  <= cnt_d;
      np_q   <= np_d;
    end
  end

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int DW     = 10,
  parameter int NF     = 8,
  parameter int PWR_W  = 4,
  parameter int WAKE_W = 24,
  parameter int LP_W   = 8,
  parameter int NP_W   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_enable_i,
  input  logic              cfg_oneshot_i,
  input  logic              cfg_lowpwr_i,
  input  logic [PWR_W-1:0]  cfg_pwrup_i,
  input  logic [WAKE_W-1:0] cfg_wake_i,
  input  logic [LP_W-1:0]   cfg_lp_cnt_i,
  input  logic [NP_W-1:0]   cfg_np_cnt_i,
  input  logic              cfg_swrst_i,
  input  logic              adc_valid_i,
  input  logic [DW-1:0]     adc_data_i,
  input  logic [NF-1:0]     filt_match_i,
  output logic              adc_pd_o,
  output logic [NCH-1:0]    adc_sel_o,
  output logic [NCH*DW-1:0] chan_val_o,
  output logic              oneshot_done_o,
  output logic              match_o,
  output logic [NF-1:0]     match_vec_o
);

  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam logic [CW-1:0] LAST_CH = CW'(NCH - 1);

  scan_state_e state_q, state_d;
  logic [CW-1:0] ch_q, ch_d;
  logic          halt, take, round_end;
  logic          tmr_clr, tmr_en, tmr_exp;
  logic [WAKE_W-1:0] tmr_lim;
  logic          dbn_clr, dbn_round, dbn_fire, dbn_sleep;
  logic          done_q, done_d, match_q, match_d;
  logic [NF-1:0] mvec_q, mvec_d;

  assign halt      = !cfg_enable_i || cfg_swrst_i;
  assign take      = !halt && (state_q == ST_SAMPLE) && adc_valid_i;
  assign round_end = take && (ch_q == LAST_CH);

  // Next-state logic
  always_comb begin
    state_d = state_q;
    ch_d    = ch_q;
    if (halt) begin
      state_d = ST_IDLE;
      ch_d    = '0;
    end else begin
      unique case (state_q)
        ST_IDLE:   state_d = ST_PWRUP;
        ST_PWRUP:  if (tmr_exp) state_d = ST_SETTLE;
        ST_SETTLE: begin
          state_d = ST_SAMPLE;
          ch_d    = '0;
        end
        ST_SAMPLE: begin
          if (adc_valid_i) begin
            if (ch_q == LAST_CH) begin
              ch_d = '0;
              if (cfg_oneshot_i)  state_d = ST_DONE;
              else if (dbn_sleep) state_d = ST_SLEEP;
            end else begin
              ch_d = ch_q + 1'b1;
            end
          end
        end
        ST_SLEEP:  if (tmr_exp) state_d = ST_PWRUP;
        ST_DONE:   state_d = ST_DONE;
        default:   state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ch_q    <= '0;
    end else begin
      state_q <= state_d;
      ch_q    <= ch_d;
    end
  end

  // Shared delay timer: restarts on every state change.
  assign tmr_clr = halt || (state_d != state_q);
  assign tmr_en  = (state_q == ST_PWRUP) || (state_q == ST_SLEEP);
  assign tmr_lim = (state_q == ST_SLEEP) ? cfg_wake_i : WAKE_W'(cfg_pwrup_i);

  adc_scan_timer #(.W(WAKE_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (tmr_clr),
    .en_i   (tmr_en),
    .lim_i  (tmr_lim),
    .exp_o  (tmr_exp)
  );

  adc_scan_capture #(.NCH(NCH), .DW(DW), .CW(CW)) u_capture (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (take),
    .ch_i   (ch_q),
    .data_i (adc_data_i),
    .val_o  (chan_val_o)
  );

  assign dbn_clr   = halt || (state_q == ST_IDLE);
  assign dbn_round = round_end && !cfg_oneshot_i;

  adc_scan_debounce #(.NF(NF), .LP_W(LP_W), .NP_W(NP_W)) u_debounce (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (dbn_clr),
    .round_i   (dbn_round),
    .lowpwr_i  (cfg_lowpwr_i),
    .lp_need_i (cfg_lp_cnt_i),
    .np_need_i (cfg_np_cnt_i),
    .vec_i     (filt_match_i),
    .fire_o    (dbn_fire),
    .sleep_o   (dbn_sleep)
  );

  // Event registers
  always_comb begin
    done_d  = round_end && cfg_oneshot_i;
    match_d = dbn_fire;
    mvec_d  = dbn_fire ? filt_match_i : mvec_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q  <= 1'b0;
      match_q <= 1'b0;
      mvec_q  <= '0;
    end else begin
      done_q  <= done_d;
      match_q <= match_d;
      mvec_q  <= mvec_d;
    end
  end

  // Moore outputs
  assign adc_pd_o = (state_q == ST_IDLE) || (state_q == ST_SLEEP) || (state_q == ST_DONE);
  for (genvar g = 0; g < NCH; g++) begin : g_sel
    assign adc_sel_o[g] = (state_q == ST_SAMPLE) && (ch_q == CW'(g));
  end

  assign oneshot_done_o = done_q;
  assign match_o        = match_q;
  assign match_vec_o    = mvec_q;

endmodule

// File: rtl/adc_scan_chk.sv
module adc_scan_chk #(
  parameter int NCH = 2,
  parameter int DW  = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_enable_i,
  input logic              cfg_swrst_i,
  input logic              adc_valid_i,
  input logic [DW-1:0]     adc_data_i,
  input logic              adc_pd_o,
  input logic [NCH-1:0]    adc_sel_o,
  input logic [NCH*DW-1:0] chan_val_o,
  input logic              oneshot_done_o,
  input logic              match_o
);

  assert_idle_when_off_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_enable_i |=> (adc_pd_o && (adc_sel_o == '0) && !match_o && !oneshot_done_o));

  assert_settle_gap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(adc_sel_o != '0) |-> ($past(!adc_pd_o) && $past(adc_sel_o == '0)));

  assert_sel_onehot_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(adc_sel_o));

  assert_no_sel_when_down_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_pd_o |-> (adc_sel_o == '0));

  assert_capture_ch0_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adc_valid_i && adc_sel_o[0] && cfg_enable_i && !cfg_swrst_i)
      |=> (chan_val_o[DW-1:0] == $past(adc_data_i)));

  assert_swrst_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_swrst_i |=> (adc_pd_o && (adc_sel_o == '0)));

  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oneshot_done_o |=> !oneshot_done_o);

  assert_match_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |=> !match_o);

endmodule

bind adc_scan_seq adc_scan_chk #(.NCH(NCH), .DW(DW)) u_chk (.*);

// File: tb/sim_adc_scan_seq.sv
`timescale 1ns/1ps
module sim_adc_scan_seq;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        cfg_enable_i, cfg_oneshot_i, cfg_lowpwr_i, cfg_swrst_i;
  logic [3:0]  cfg_pwrup_i;
  logic [23:0] cfg_wake_i;
  logic [7:0]  cfg_lp_cnt_i;
  logic [15:0] cfg_np_cnt_i;
  logic        adc_valid_i;
  logic [9:0]  adc_data_i;
  logic [7:0]  filt_match_i;
  logic        adc_pd_o;
  logic [1:0]  adc_sel_o;
  logic [19:0] chan_val_o;
  logic        oneshot_done_o, match_o;
  logic [7:0]  match_vec_o;

  always #5 clk_i = ~clk_i;

  adc_scan_seq u0 (.*);

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // converter model and monitor state
  bit         model_on, gap, tog, pd_seen;
  int         rnd, rnd_limit, match_cnt, match_round, done_cnt, sel_cycles;
  int         run, last_run, drv;
  logic [7:0] vecs [0:15];
  logic [7:0] last_vec;
  bit         slept [0:15];
  logic [1:0] sel_log [0:3];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk_i) begin
    if (match_o) begin match_cnt++; match_round = rnd; last_vec = match_vec_o; end
    if (oneshot_done_o) done_cnt++;
    if (adc_sel_o != 2'b00) sel_cycles++;
    if (cfg_enable_i && adc_pd_o) begin
      pd_seen = 1; run++;
    end else begin
      if (run != 0) last_run = run;
      run = 0;
    end
    adc_valid_i = 1'b0;
    if (model_on && adc_sel_o != 2'b00 && rnd < rnd_limit) begin
      if (!gap || tog) begin
        tog = 0;
        adc_valid_i = 1'b1;
        if (drv < 4) sel_log[drv] = adc_sel_o;
        drv++;
        if (adc_sel_o == 2'b01) begin
          if (rnd + 1 < 16) slept[rnd+1] = pd_seen;
          pd_seen = 0;
          adc_data_i = 10'(16 * (rnd + 1) + 1);
        end else begin
          adc_data_i = 10'(16 * (rnd + 1) + 2);
          filt_match_i = vecs[rnd];
          rnd++;
        end
      end else begin
        tog = 1;
      end
    end
  end

  task automatic clear_model();
    model_on = 0; gap = 0; tog = 0; pd_seen = 0; rnd = 0; rnd_limit = 0;
    match_cnt = 0; match_round = 0; done_cnt = 0; sel_cycles = 0;
    run = 0; last_run = 0; drv = 0; last_vec = '0;
    for (int i = 0; i < 16; i++) begin vecs[i] = '0; slept[i] = 0; end
    for (int i = 0; i < 4; i++) sel_log[i] = '0;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wait_rounds(input int n);
    for (int i = 0; i < 2000 && rnd < n; i++) @(negedge clk_i);
  endtask

  task automatic stop_run(input string tag);
    @(negedge clk_i); #1;
    cfg_enable_i = 1'b0;
    step(2);
    chk({tag, " R1 pd after enable drop"}, 32'(adc_pd_o), 32'd1);
    chk({tag, " R1 sel after enable drop"}, 32'(adc_sel_o), 32'd0);
    model_on = 0;
    step(2);
  endtask

  task automatic t_reset();
    chk("R1 reset pd", 32'(adc_pd_o), 32'd1);
    chk("R1 reset sel", 32'(adc_sel_o), 32'd0);
    chk("R1 reset events", 32'({oneshot_done_o, match_o}), 32'd0);
    clear_model();
    model_on = 1; rnd_limit = 4;
    step(10);
    chk("R1 disabled stays idle", 32'({adc_pd_o, adc_sel_o}), 32'b100);
    model_on = 0;
  endtask

  task automatic t_powerup(input logic [3:0] p);
    int cnt = 0;
    clear_model();
    cfg_pwrup_i = p;
    @(negedge clk_i); #1;
    cfg_enable_i = 1'b1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk_i);
      if (adc_sel_o != 2'b00) break;
      if (!adc_pd_o) cnt++;
    end
    chk($sformatf("R2 powerup gap p=%0d", p), 32'(cnt), 32'((p == 0 ? 1 : int'(p)) + 1));
    chk("R5 first select is channel 0", 32'(adc_sel_o), 32'b01);
    stop_run("powerup");
  endtask

  task automatic t_oneshot();
    clear_model();
    cfg_oneshot_i = 1'b1; cfg_pwrup_i = 4'd2;
    gap = 1; model_on = 1; rnd_limit = 1; vecs[0] = 8'hff;
    @(negedge clk_i); #1;
    cfg_enable_i = 1'b1;
    for (int i = 0; i < 200 && done_cnt == 0; i++) @(negedge clk_i);
    step(6);
    chk("R8 done pulses once", 32'(done_cnt), 32'd1);
    chk("R8 filter ignored, no match", 32'(match_cnt), 32'd0);
    chk("R8 powered down after done", 32'({adc_pd_o, adc_sel_o}), 32'b100);
    chk("R5 select held until valid", 32'(sel_cycles), 32'd4);
    chk("R5 order ch0", 32'(sel_log[0]), 32'b01);
    chk("R5 order ch1", 32'(sel_log[1]), 32'b10);
    chk("R6 oneshot values", 32'(chan_val_o), 32'({10'd18, 10'd17}));
    cfg_oneshot_i = 1'b0;
    stop_run("oneshot");
  endtask

  task automatic run_normal(input int np, input int nr, input logic [7:0] v [0:15]);
    clear_model();
    cfg_lowpwr_i = 1'b0; cfg_pwrup_i = 4'd1; cfg_np_cnt_i = 16'(np);
    for (int i = 0; i < 16; i++) vecs[i] = v[i];
    model_on = 1; rnd_limit = nr;
    @(negedge clk_i); #1;
    cfg_enable_i = 1'b1;
    step(2);
    pd_seen = 0;
    wait_rounds(nr);
    step(4);
  endtask

  task automatic t_normal();
    logic [7:0] v [0:15];
    for (int i = 0; i < 16; i++) v[i] = 8'h05;
    run_normal(3, 6, v);
    chk("R10 one match in six rounds", 32'(match_cnt), 32'd1);
    chk("R10 match on round 4", 32'(match_round), 32'd4);
    chk("R10 match vector", 32'(last_vec), 32'h05);
    chk("R6 latest values", 32'(chan_val_o), 32'({10'(16*6+2), 10'(16*6+1)}));
    chk("R10 continuous mode never powers down", 32'(pd_seen), 32'd0);
    stop_run("normal");
  endtask

  task automatic t_mismatch();
    logic [7:0] v [0:15];
    for (int i = 0; i < 16; i++) v[i] = (i < 2) ? 8'h05 : 8'h06;
    run_normal(3, 6, v);
    chk("R9 change restarts count", 32'(match_cnt), 32'd1);
    chk("R9 match moves to round 6", 32'(match_round), 32'd6);
    chk("R9 vector of new pattern", 32'(last_vec), 32'h06);
    stop_run("mismatch");
    for (int i = 0; i < 16; i++) v[i] = 8'h00;
    run_normal(1, 8, v);
    chk("R9 all-zero vector never matches", 32'(match_cnt), 32'd0);
    stop_run("zero");
    for (int i = 0; i < 16; i++) v[i] = 8'h07;
    run_normal(0, 3, v);
    chk("R10 zero threshold acts as one", 32'(match_cnt), 32'd2);
    chk("R10 last match round", 32'(match_round), 32'd3);
    stop_run("np1");
  endtask

  task automatic t_lowpower();
    bit exp_sl [2:9];
    clear_model();
    cfg_lowpwr_i = 1'b1; cfg_lp_cnt_i = 8'd2; cfg_np_cnt_i = 16'd2;
    cfg_wake_i = 24'd5; cfg_pwrup_i = 4'd1;
    for (int i = 0; i < 16; i++) vecs[i] = 8'h03;
    vecs[7] = 8'h09;
    exp_sl = '{1, 1, 0, 0, 1, 1, 0, 1};
    model_on = 1; rnd_limit = 9;
    @(negedge clk_i); #1;
    cfg_enable_i = 1'b1;
    step(2);
    pd_seen = 0;
    wait_rounds(9);
    step(30);
    for (int k = 2; k <= 9; k++) begin
      string tg;
      tg = (k == 4 || k == 5) ? "R4" : ((k == 6 || k == 9) ? "R11" : "R3");
      chk($sformatf("%s sleep before round %0d", tg, k), 32'(slept[k]), 32'(exp_sl[k]));
    end
    chk("R11 single confirmed match", 32'(match_cnt), 32'd1);
    chk("R4 match after low then normal tier", 32'(match_round), 32'd5);
    chk("R3 sleep length", 32'(last_run), 32'd5);
    cfg_lowpwr_i = 1'b0;
    stop_run("lowpower");
  endtask

  task automatic t_swrst();
    logic [7:0] v [0:15];
    clear_model();
    cfg_lowpwr_i = 1'b0; cfg_np_cnt_i = 16'd3; cfg_pwrup_i = 4'd1;
    for (int i = 0; i < 16; i++) vecs[i] = 8'h05;
    model_on = 1; rnd_limit = 7;
    @(negedge clk_i); #1;
    cfg_enable_i = 1'b1;
    wait_rounds(2);
    #1 cfg_swrst_i = 1'b1;
    step(2);
    chk("R7 soft reset powers down", 32'(adc_pd_o), 32'd1);
    chk("R7 soft reset clears select", 32'(adc_sel_o), 32'd0);
    step(5);
    chk("R7 held while soft reset", 32'({adc_pd_o, adc_sel_o}), 32'b100);
    #1 cfg_swrst_i = 1'b0;
    wait_rounds(7);
    step(4);
    chk("R7 debounce restarted, one match", 32'(match_cnt), 32'd1);
    chk("R7 match on round 6", 32'(match_round), 32'd6);
    stop_run("swrst");
    for (int i = 0; i < 16; i++) v[i] = '0;
  endtask

  initial begin
    rst_ni = 1'b0;
    cfg_enable_i = 0; cfg_oneshot_i = 0; cfg_lowpwr_i = 0; cfg_swrst_i = 0;
    cfg_pwrup_i = 4'd7; cfg_wake_i = 24'd1600; cfg_lp_cnt_i = 8'd4; cfg_np_cnt_i = 16'd155;
    adc_valid_i = 0; adc_data_i = '0; filt_match_i = '0;
    clear_model();
    step(3);
    #1 rst_ni = 1'b1;
    step(1);
    t_reset();
    t_powerup(4'd3);
    t_powerup(4'd0);
    t_powerup(4'd15);
    t_oneshot();
    t_normal();
    t_mismatch();
    t_lowpower();
    t_swrst();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=expired expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule